// File: doc/BRIEF.md
# Multiplexed BCD Load and Scan Controller

This block runs a shared four-bit BCD port and a set of digit strobes, one per display digit. In normal operation it steps through the latched digits on each scan tick, from the most significant digit down to the least significant, and drives the selected digit onto the port. A load request turns the port into an input. The block then accepts one digit per scan slot and passes each digit to the counter, to the holding register, or to both, using per-digit write enables.

Each of the two load controls has three levels, carried on two bits: `2'b00` is low, `2'b01` is open and `2'b10` is high. The code `2'b11` behaves as open. A control that moves into high starts a load. The scan returns to the most significant digit, and complete passes over all digits follow. Both controls are sampled again only when a pass ends. Holding the register control low blanks the display and parks the scan. Holding the counter control low only releases the port. The `load_busy` output is meant to inhibit the external counter while digits are being loaded.

Top module: `bcd_scan_load`

## Requirements
- R1: After reset, with both controls open, the scan sits on the most significant digit. The strobe is `4'b1000` and the port is enabled and drives that digit. `load_busy` is 0 and no write enable is set.
- R2: In normal mode each `scan_tick` moves the single active strobe one digit toward the least significant digit (bit 3 down to bit 0), then wraps to bit 3. `bcd_out` carries the latched digit of the active strobe, and `latch_digits[15:12]` is the most significant digit.
- R3: A control that changes into high (`2'b10`) raises `load_busy` after the next clock edge and puts the strobe on the most significant digit. While loading, `bcd_oe` is 0.
- R4: During a load, a `scan_tick` ends the current slot. In that same cycle the write enable of the strobed digit pulses and `wr_data` equals `bcd_in`. Slots go from the most significant digit to the least significant. No write enable is ever set outside a load.
- R5: If only the counter control was high at the start of the pass, only `cnt_we` pulses. If only the register control was high, only `reg_we` pulses. If both were high, both pulse.
- R6: On the tick that ends the last slot, the controls are sampled again. If either is high, a new pass starts at the most significant digit with targets taken from that sample. Otherwise normal scanning resumes at the most significant digit. A request that arrives in the middle of a pass does not restart it.
- R7: `load_busy` stays high from the request until the tick that ends the final pass.
- R8: With the register control low and no load in progress, `display_en` is 0, every strobe is 0, `bcd_oe` is 0, and the scan position does not move on ticks.
- R9: With the counter control low, `bcd_oe` is 0. Scanning continues and no write enable is set.
- R10: The code `2'b11` on a control acts as open. It neither starts a load nor disables the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | Slot advance enable, ends the current slot |
| ctl_cnt | input | 2 | Counter load control (00 low, 01 open, 10 high) |
| ctl_reg | input | 2 | Register load control (00 low, 01 open, 10 high) |
| latch_digits | input | 16 | Latched digits, most significant in the top nibble |
| bcd_in | input | 4 | Port data while acting as input |
| digit_strobe | output | 4 | One-hot digit strobes, bit 3 is the most significant |
| bcd_oe | output | 1 | Port output enable |
| bcd_out | output | 4 | Port output data |
| cnt_we | output | 4 | Per-digit counter write enables |
| reg_we | output | 4 | Per-digit register write enables |
| wr_data | output | 4 | Digit to be written |
| display_en | output | 1 | Display drivers enabled |
| load_busy | output | 1 | Load in progress, counting inhibited |

## Verification
The write enables, `wr_data`, `bcd_oe` and `display_en` are combinational in the tick and control inputs. The bench therefore checks them shortly after it drives those inputs, before the next rising edge. Strobe position and `load_busy` change one edge after the tick or request that causes them, so the bench checks them one nanosecond after that edge. A bench-side scan position, advanced only on ticks the requirements say count, gives the expected strobe for every check.

// File: rtl/bcdscan_pkg.sv
package bcdscan_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_OPEN = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSVD = 2'b11
  } tri_lvl_e;

  function automatic logic lvl_is_high(input logic [1:0] v);
    return v == LVL_HIGH;
  endfunction

  function automatic logic lvl_is_low(input logic [1:0] v);
    return v == LVL_LOW;
  endfunction

endpackage

// File: rtl/bcdscan_lvl_sense.sv
module bcdscan_lvl_sense
  import bcdscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl,
  output logic       is_high,
  output logic       is_low,
  output logic       rise_high
);

  logic prev_high_q;
  logic prev_high_d;

  always_comb begin
    is_high     = lvl_is_high(lvl);
    is_low      = lvl_is_low(lvl);
    rise_high   = is_high & ~prev_high_q;
    prev_high_d = is_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_high_q <= 1'b0;
    else        prev_high_q <= prev_high_d;
  end

endmodule

// File: rtl/bcdscan_pos.sv
module bcdscan_pos #(
  parameter int NUM_DIGITS = 4,
  localparam int PW = $clog2(NUM_DIGITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          restart,
  output logic [PW-1:0] pos,
  output logic          last
);

  localparam logic [PW-1:0] LAST_POS = PW'(NUM_DIGITS - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_d;

  always_comb begin
    last  = (pos_q == LAST_POS);
    pos_d = pos_q;
    if (restart)   pos_d = '0;
    else if (adv)  pos_d = last ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/bcdscan_load_fsm.sv
module bcdscan_load_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic tick,
  input  logic last,
  input  logic cnt_high,
  input  logic reg_high,
  output logic busy,
  output logic tgt_cnt,
  output logic tgt_reg,
  output logic start
);

  logic busy_q, busy_d;
  logic tgt_cnt_q, tgt_cnt_d;
  logic tgt_reg_q, tgt_reg_d;
  logic pass_end, again;

  always_comb begin
    start     = ~busy_q & req;
    pass_end  = busy_q & tick & last;
    again     = pass_end & (cnt_high | reg_high);
    busy_d    = busy_q;
    tgt_cnt_d = tgt_cnt_q;
    tgt_reg_d = tgt_reg_q;
    if (start) begin
      busy_d    = 1'b1;
      tgt_cnt_d = cnt_high;
      tgt_reg_d = reg_high;
    end else if (pass_end) begin
      busy_d    = again;
      tgt_cnt_d = again & cnt_high;
      tgt_reg_d = again & reg_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tgt_cnt_q <= 1'b0;
      tgt_reg_q <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      tgt_cnt_q <= tgt_cnt_d;
      tgt_reg_q <= tgt_reg_d;
    end
  end

  assign busy    = busy_q;
  assign tgt_cnt = tgt_cnt_q;
  assign tgt_reg = tgt_reg_q;

endmodule

// File: rtl/bcd_scan_load.sv
module bcd_scan_load #(
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_W    = 4,
  localparam int PW        = $clog2(NUM_DIGITS),
  localparam int LW        = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_tick,
  input  logic [1:0]            ctl_cnt,
  input  logic [1:0]            ctl_reg,
  input  logic [LW-1:0]         latch_digits,
  input  logic [DIGIT_W-1:0]    bcd_in,
  output logic [NUM_DIGITS-1:0] digit_strobe,
  output logic                  bcd_oe,
  output logic [DIGIT_W-1:0]    bcd_out,
  output logic [NUM_DIGITS-1:0] cnt_we,
  output logic [NUM_DIGITS-1:0] reg_we,
  output logic [DIGIT_W-1:0]    wr_data,
  output logic                  display_en,
  output logic                  load_busy
);

  logic cnt_high, cnt_low, cnt_rise;
  logic reg_high, reg_low, reg_rise;
  logic busy, tgt_cnt, tgt_reg, start;
  logic adv, last;
  logic [PW-1:0] pos;
  logic [NUM_DIGITS-1:0] digit_sel;

  bcdscan_lvl_sense u_sense_cnt (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_cnt),
    .is_high(cnt_high), .is_low(cnt_low), .rise_high(cnt_rise)
  );

  bcdscan_lvl_sense u_sense_reg (
    .clk(clk), .rst_n(rst_n), .lvl(ctl_reg),
    .is_high(reg_high), .is_low(reg_low), .rise_high(reg_rise)
  );

  bcdscan_load_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(cnt_rise | reg_rise), .tick(scan_tick),
    .last(last), .cnt_high(cnt_high), .reg_high(reg_high),
    .busy(busy), .tgt_cnt(tgt_cnt), .tgt_reg(tgt_reg), .start(start)
  );

  bcdscan_pos #(.NUM_DIGITS(NUM_DIGITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(adv), .restart(start),
    .pos(pos), .last(last)
  );

  always_comb begin
    display_en = ~reg_low | busy;
    adv        = scan_tick & display_en;
    bcd_oe     = display_en & ~busy & ~cnt_low & ~cnt_high & ~reg_high;
    wr_data    = bcd_in;
    load_busy  = busy;
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    assign digit_sel[d]    = (pos == PW'(NUM_DIGITS - 1 - d));
    assign digit_strobe[d] = digit_sel[d] & display_en;
    assign cnt_we[d]       = busy & tgt_cnt & scan_tick & digit_sel[d];
    assign reg_we[d]       = busy & tgt_reg & scan_tick & digit_sel[d];
  end

  always_comb begin
    bcd_out = '0;
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (digit_sel[d]) bcd_out = latch_digits[d*DIGIT_W +: DIGIT_W];
    end
  end

endmodule

// File: rtl/bcdscan_chk.sv
module bcdscan_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scan_tick,
  input logic [NUM_DIGITS-1:0] digit_strobe,
  input logic                  bcd_oe,
  input logic [NUM_DIGITS-1:0] cnt_we,
  input logic [NUM_DIGITS-1:0] reg_we,
  input logic                  display_en,
  input logic                  load_busy
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    display_en |-> $countones(digit_strobe) == 1); // R2

  AST_LOAD_STARTS_MSD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_busy) |-> digit_strobe[NUM_DIGITS-1]); // R3

  AST_PORT_OFF_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> !bcd_oe); // R3

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_busy |-> (cnt_we == '0 && reg_we == '0)); // R4

  AST_WRITE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_we | reg_we) & ~digit_strobe) == '0); // R4

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && !scan_tick) |=> load_busy); // R7

  AST_DARK_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !display_en |-> (digit_strobe == '0 && !bcd_oe)); // R8

endmodule

bind bcd_scan_load bcdscan_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .digit_strobe(digit_strobe),
  .bcd_oe(bcd_oe), .cnt_we(cnt_we), .reg_we(reg_we),
  .display_en(display_en), .load_busy(load_busy)
);

// File: tb/test_bcd_scan_load.sv
`timescale 1ns/100ps
module test_bcd_scan_load;

  localparam logic [1:0] L_LOW = 2'b00, L_OPEN = 2'b01, L_HIGH = 2'b10, L_RSVD = 2'b11;

  logic        clk;
  logic        rst_n;
  logic        scan_tick;
  logic [1:0]  ctl_cnt, ctl_reg;
  logic [15:0] latch_digits;
  logic [3:0]  bcd_in;
  logic [3:0]  digit_strobe, bcd_out, cnt_we, reg_we, wr_data;
  logic        bcd_oe, display_en, load_busy;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_pos  = 0;
  bit done     = 0;

  bcd_scan_load i_bcd_scan_load (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .ctl_cnt(ctl_cnt),
    .ctl_reg(ctl_reg), .latch_digits(latch_digits), .bcd_in(bcd_in),
    .digit_strobe(digit_strobe), .bcd_oe(bcd_oe), .bcd_out(bcd_out),
    .cnt_we(cnt_we), .reg_we(reg_we), .wr_data(wr_data),
    .display_en(display_en), .load_busy(load_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] strobe_of(input int p);
    return 4'b1000 >> p;
  endfunction

  task automatic step(input bit t);
    scan_tick = t;
    @(posedge clk);
    #1;
    scan_tick = 1'b0;
    if (t && display_en) exp_pos = (exp_pos + 1) % 4;
  endtask

  task automatic t_reset;
    check(digit_strobe == 4'b1000, "R1", "strobe", digit_strobe, 4'b1000);
    check(bcd_oe == 1'b1, "R1", "oe", bcd_oe, 1);
    check(bcd_out == latch_digits[15:12], "R1", "out", bcd_out, latch_digits[15:12]);
    check(load_busy == 1'b0, "R1", "busy", load_busy, 0);
    check((cnt_we | reg_we) == 4'b0, "R1", "we", cnt_we | reg_we, 0);
  endtask

  task automatic t_scan;
    latch_digits = 16'h4721;
    #1;
    for (int i = 0; i < 6; i++) begin
      check(digit_strobe == strobe_of(exp_pos), "R2", "strobe", digit_strobe, strobe_of(exp_pos));
      check(bcd_out == latch_digits[(3-exp_pos)*4 +: 4], "R2", "out", bcd_out,
            latch_digits[(3-exp_pos)*4 +: 4]);
      check(bcd_oe == 1'b1, "R2", "oe", bcd_oe, 1);
      step(1);
    end
    while (exp_pos != 0) step(1);
  endtask

  task automatic t_load(input bit c, input bit r, input logic [15:0] val);
    ctl_cnt = c ? L_HIGH : L_OPEN;
    ctl_reg = r ? L_HIGH : L_OPEN;
    step(0);
    check(load_busy == 1'b1, "R3", "busy after request", load_busy, 1);
    check(digit_strobe == 4'b1000, "R3", "strobe at start", digit_strobe, 4'b1000);
    check(bcd_oe == 1'b0, "R3", "oe in load", bcd_oe, 0);
    ctl_cnt = L_OPEN;
    ctl_reg = L_OPEN;
    for (int i = 0; i < 4; i++) begin
      bcd_in    = val[(3-i)*4 +: 4];
      scan_tick = 1'b1;
      #1;
      check(cnt_we == (c ? strobe_of(i) : 4'b0), "R5", "cnt_we", cnt_we, c ? strobe_of(i) : 4'b0);
      check(reg_we == (r ? strobe_of(i) : 4'b0), "R5", "reg_we", reg_we, r ? strobe_of(i) : 4'b0);
      check(wr_data == val[(3-i)*4 +: 4], "R4", "wr_data", wr_data, val[(3-i)*4 +: 4]);
      @(posedge clk);
      #1;
      scan_tick = 1'b0;
      if (i < 3) check(load_busy == 1'b1, "R7", "busy mid pass", load_busy, 1);
    end
    exp_pos = 0;
    check(load_busy == 1'b0, "R6", "busy after pass", load_busy, 0);
    check(bcd_oe == 1'b1, "R6", "oe restored", bcd_oe, 1);
    check(digit_strobe == 4'b1000, "R6", "strobe restored", digit_strobe, 4'b1000);
  endtask

  task automatic t_resample;
    ctl_cnt = L_HIGH;
    step(0);
    ctl_cnt = L_OPEN;
    step(1);
    step(1);
    ctl_reg = L_HIGH;
    step(0);
    check(digit_strobe == 4'b0010, "R6", "no restart mid pass", digit_strobe, 4'b0010);
    for (int i = 2; i < 4; i++) begin
      scan_tick = 1'b1;
      bcd_in    = 4'(i);
      #1;
      check(cnt_we == strobe_of(i) && reg_we == 4'b0, "R4", "first pass we",
            {cnt_we, reg_we}, {strobe_of(i), 4'b0});
      @(posedge clk);
      #1;
      scan_tick = 1'b0;
    end
    check(load_busy == 1'b1, "R6", "second pass", load_busy, 1);
    check(digit_strobe == 4'b1000, "R6", "second pass at MSD", digit_strobe, 4'b1000);
    ctl_reg = L_OPEN;
    for (int i = 0; i < 4; i++) begin
      scan_tick = 1'b1;
      #1;
      check(reg_we == strobe_of(i) && cnt_we == 4'b0, "R5", "second pass targets",
            {cnt_we, reg_we}, {4'b0, strobe_of(i)});
      @(posedge clk);
      #1;
      scan_tick = 1'b0;
      if (i < 3) check(load_busy == 1'b1, "R7", "busy second pass", load_busy, 1);
    end
    check(load_busy == 1'b0, "R7", "busy end", load_busy, 0);
    exp_pos = 0;
  endtask

  task automatic t_display_off;
    step(1);
    ctl_reg = L_LOW;
    #1;
    check(display_en == 1'b0, "R8", "display_en", display_en, 0);
    check(digit_strobe == 4'b0, "R8", "strobes", digit_strobe, 0);
    check(bcd_oe == 1'b0, "R8", "oe", bcd_oe, 0);
    step(1);
    step(1);
    ctl_reg = L_OPEN;
    #1;
    check(digit_strobe == strobe_of(exp_pos) && exp_pos == 1, "R8", "position held",
          digit_strobe, 4'b0100);
  endtask

  task automatic t_cnt_low;
    ctl_cnt = L_LOW;
    #1;
    check(bcd_oe == 1'b0, "R9", "oe", bcd_oe, 0);
    check(digit_strobe == 4'b0100, "R9", "strobe", digit_strobe, 4'b0100);
    scan_tick = 1'b1;
    bcd_in    = 4'h9;
    #1;
    check((cnt_we | reg_we) == 4'b0, "R9", "no write", cnt_we | reg_we, 0);
    @(posedge clk);
    #1;
    scan_tick = 1'b0;
    exp_pos = 2;
    check(digit_strobe == 4'b0010, "R9", "scan continues", digit_strobe, 4'b0010);
    check(load_busy == 1'b0, "R9", "no load", load_busy, 0);
    ctl_cnt = L_OPEN;
    while (exp_pos != 0) step(1);
  endtask

  task automatic t_rsvd;
    ctl_cnt = L_RSVD;
    step(0);
    check(load_busy == 1'b0, "R10", "no load", load_busy, 0);
    check(bcd_oe == 1'b1, "R10", "oe", bcd_oe, 1);
    ctl_cnt = L_OPEN;
    step(0);
  endtask

  initial begin
    rst_n = 1'b0; scan_tick = 1'b0; ctl_cnt = L_OPEN; ctl_reg = L_OPEN;
    latch_digits = 16'h9305; bcd_in = 4'h0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    t_reset;
    t_scan;
    t_load(1'b1, 1'b0, 16'h1234);
    t_load(1'b0, 1'b1, 16'h5678);
    t_load(1'b1, 1'b1, 16'h9021);
    t_resample;
    t_display_off;
    t_cnt_low;
    t_rsvd;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule